// File: doc/BRIEF.md
# UART Flow Controller

This block sits between a UART's byte transmitter and receiver and their FIFOs, and it enforces flow control on both directions. It has three resolved modes: off, hardware handshaking on `cts_n`/`rts_n`, and in-band software flow control.

In software mode the block watches the received stream for a pause character and a resume character, and it removes both from the stream. It can also escape transmitted bytes that would otherwise look like control characters. Transmit bytes are handed over with a valid/ready handshake, where one handshake is one character. Received bytes arrive as single-cycle strobes and leave, filtered, one cycle later.

Three interrupt flags are kept: pause-received, RTS-change and CTS-change. They are sticky, each is cleared by software, and they are merged into one interrupt line. Configuration comes in as static inputs: a feature byte, an interrupt-enable byte, two character pairs, the escape byte and an escape enable.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is held at a clock edge, `rts_n` is 1, `rx_out_valid` is 0, `irq_flags` is 0 and `irq` is 0.
- R2: The feature byte is decoded as follows. Bit 4 enables all flow control. The low nibble 0xA selects software mode with pair 1, and 0x5 selects software mode with pair 2; any other nibble selects no software mode. When software mode is selected, bits 7 and 6 are ignored. With bit 4 clear, every byte passes as in R3.
- R3: With software mode off, a transmit byte appears unchanged on `tx_out_data` in the same cycle. A received byte appears on `rx_out_data` with `rx_out_valid` one clock later, control characters included.
- R4: When hardware mode is active and feature bit 7 is set, `tx_out_valid` and `tx_in_ready` stay 0 while `cts_n` is 1. A character is handed over only while `cts_n` is 0.
- R5: `rts_n` is a register. With feature bit 6 set in hardware mode, it becomes 1 when `rx_level` is at or above `RX_HIGH_MARK`, and 0 when `rx_level` is below it. Without automatic RTS it is 0 after the first clock following reset.
- R6: With software mode and `cfg_esc_en` set, a transmit byte equal to the selected pause, resume or escape character goes out as two characters: first the escape byte, then the byte XOR 0x20. `tx_in_ready` rises only with the second character.
- R7: With `cfg_esc_en` clear, no transmit byte is escaped, and a received escape byte is forwarded as data.
- R8: In software mode with escaping on, a received escape byte is dropped. The next received byte is forwarded XOR 0x20 and is never taken as a control character.
- R9: In software mode, a received unescaped pause character blocks `tx_out_valid` from the next cycle on. The resume character unblocks it. Neither character is forwarded. Leaving software mode releases the block.
- R10: `irq_flags[0]` is set when a pause character is received in software mode while `cfg_ier` bit 5 is 1. It stays set until `irq_clr[0]` is pulsed.
- R11: In hardware mode, `irq_flags[2]` is set one clock after `cts_n` changes if `cfg_ier` bit 7 is 1. `irq_flags[1]` is set one clock after `rts_n` changes if `cfg_ier` bit 6 is 1. In other modes neither flag is set.
- R12: `irq` is the OR of `irq_flags`. Pulsing a bit of `irq_clr` clears that flag, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_feature | input | 8 | Feature byte: bit 7 auto CTS, bit 6 auto RTS, bit 4 enable, [3:0] character-pair select |
| cfg_ier | input | 8 | Interrupt enables: bit 7 CTS change, bit 6 RTS change, bit 5 pause received |
| cfg_xon1 | input | DATA_W | Resume character, pair 1 |
| cfg_xoff1 | input | DATA_W | Pause character, pair 1 |
| cfg_xon2 | input | DATA_W | Resume character, pair 2 |
| cfg_xoff2 | input | DATA_W | Pause character, pair 2 |
| cfg_esc_char | input | DATA_W | Escape byte |
| cfg_esc_en | input | 1 | Escaping enable (effective only in software mode) |
| tx_in_valid | input | 1 | Transmit FIFO has a byte |
| tx_in_data | input | DATA_W | Byte at the transmit FIFO head |
| tx_in_ready | output | 1 | Pops the transmit FIFO |
| tx_out_valid | output | 1 | Character offered to the serializer |
| tx_out_data | output | DATA_W | Character to send |
| tx_out_ready | input | 1 | Serializer starts a character |
| rx_in_valid | input | 1 | Byte received strobe |
| rx_in_data | input | DATA_W | Received byte |
| rx_out_valid | output | 1 | Push strobe to the receive FIFO |
| rx_out_data | output | DATA_W | Byte to push |
| rx_level | input | LEVEL_W | Receive FIFO fill level |
| cts_n | input | 1 | Clear-to-send, active low, already synchronized |
| rts_n | output | 1 | Request-to-send, active low |
| irq_clr | input | 3 | Per-flag clear pulses |
| irq_flags | output | 3 | Sticky flags: [0] pause received, [1] RTS change, [2] CTS change |
| irq | output | 1 | OR of the flags |

## Verification
Random bytes are pushed through the transmit and receive paths in off mode, software pair-1 mode and software pair-2 mode. Comparing the modes shows whether escaping and control-character removal follow the selected pair and not a fixed value. Directed sequences cover:
- escape-then-control on receive, which tells unescaping apart from pausing;
- pause and resume with and without the interrupt enable, and with a clear landing on the same cycle;
- `cts_n` toggles in each mode.

A sweep of random fill levels around the high mark checks that `rts_n` switches at exactly the mark and not one level off.

// File: rtl/uart_fc_pkg.sv
// Package: shared constants and the resolved flow-control mode type.
// Assumes an 8-bit feature/enable byte layout fixed by the register decoder.
package uart_fc_pkg;
    localparam int FEAT_EN_BIT   = 4;
    localparam int FEAT_RTS_BIT  = 6;
    localparam int FEAT_CTS_BIT  = 7;
    localparam int IER_XOFF_BIT  = 5;
    localparam int IER_RTS_BIT   = 6;
    localparam int IER_CTS_BIT   = 7;
    localparam logic [3:0] SEL_PAIR1 = 4'hA;
    localparam logic [3:0] SEL_PAIR2 = 4'h5;
    localparam int IRQ_XOFF = 0;
    localparam int IRQ_RTS  = 1;
    localparam int IRQ_CTS  = 2;
    localparam int IRQ_N    = 3;

    typedef enum logic [1:0] {
        FC_OFF = 2'd0,
        FC_HW  = 2'd1,
        FC_SW  = 2'd2
    } fc_mode_e;
endpackage

// File: rtl/fc_mode_decode.sv
// Mode decoder: resolves the feature byte into one mode and picks the
// active pause/resume character pair. Software selection overrides the
// hardware bits. Purely combinational.
module fc_mode_decode
    import uart_fc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [7:0]        feature,
    input  logic [DATA_W-1:0] xon1,
    input  logic [DATA_W-1:0] xoff1,
    input  logic [DATA_W-1:0] xon2,
    input  logic [DATA_W-1:0] xoff2,
    output fc_mode_e          mode,
    output logic              auto_cts,
    output logic              auto_rts,
    output logic [DATA_W-1:0] xon_sel,
    output logic [DATA_W-1:0] xoff_sel
);
    logic sw_sel;

    // Decode mode, automatic handshake enables and character pair.
    always_comb begin
        sw_sel   = feature[FEAT_EN_BIT] &&
                   (feature[3:0] == SEL_PAIR1 || feature[3:0] == SEL_PAIR2);
        auto_cts = feature[FEAT_EN_BIT] && !sw_sel && feature[FEAT_CTS_BIT];
        auto_rts = feature[FEAT_EN_BIT] && !sw_sel && feature[FEAT_RTS_BIT];
        xon_sel  = (feature[3:0] == SEL_PAIR1) ? xon1  : xon2;
        xoff_sel = (feature[3:0] == SEL_PAIR1) ? xoff1 : xoff2;
        if (sw_sel)                    mode = FC_SW;
        else if (auto_cts || auto_rts) mode = FC_HW;
        else                           mode = FC_OFF;
    end
endmodule

// File: rtl/fc_tx_gate.sv
// Transmit gate: offers FIFO bytes to the serializer when CTS and the
// software pause allow it, and splits escaped bytes into two characters.
// Assumes tx_in_data is stable while tx_in_valid is high.
module fc_tx_gate #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              esc_active,
    input  logic [DATA_W-1:0] esc_char,
    input  logic [DATA_W-1:0] xon_char,
    input  logic [DATA_W-1:0] xoff_char,
    input  logic              auto_cts,
    input  logic              cts_n,
    input  logic              paused
);
    localparam logic [DATA_W-1:0] FLIP = DATA_W'(6'h20);

    logic esc_sent;
    logic need_esc;
    logic allowed;

    // Decide gating, output character and FIFO pop.
    always_comb begin
        need_esc  = esc_active &&
                    (in_data == xon_char || in_data == xoff_char || in_data == esc_char);
        allowed   = !paused && !(auto_cts && cts_n);
        out_valid = in_valid && allowed;
        if (esc_sent)      out_data = in_data ^ FLIP;
        else if (need_esc) out_data = esc_char;
        else               out_data = in_data;
        in_ready  = out_ready && allowed && (esc_sent || !need_esc);
    end

    // Remember that the escape byte of a pair has gone out.
    always_ff @(posedge clk) begin
        if (!rst_n)                      esc_sent <= 1'b0;
        else if (out_valid && out_ready) esc_sent <= !esc_sent && need_esc;
    end
endmodule

// File: rtl/fc_rx_filter.sv
// Receive filter: forwards received bytes one cycle later; in software
// mode it strips pause/resume characters, tracks the pause state and
// undoes escaping. Assumes at most one received byte per cycle.
module fc_rx_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sw_active,
    input  logic              esc_active,
    input  logic [DATA_W-1:0] esc_char,
    input  logic [DATA_W-1:0] xon_char,
    input  logic [DATA_W-1:0] xoff_char,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              paused,
    output logic              xoff_hit
);
    localparam logic [DATA_W-1:0] FLIP = DATA_W'(6'h20);

    logic esc_pend;

    // Flag an unescaped pause character arriving this cycle.
    always_comb begin
        xoff_hit = in_valid && sw_active && !esc_pend &&
                   !(esc_active && in_data == esc_char) && in_data == xoff_char;
    end

    // Classify each received byte and update forward/pause/escape state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            esc_pend  <= 1'b0;
            paused    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (!sw_active) begin
                paused   <= 1'b0;
                esc_pend <= 1'b0;
                if (in_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= in_data;
                end
            end else if (in_valid) begin
                if (esc_pend) begin
                    out_valid <= 1'b1;
                    out_data  <= in_data ^ FLIP;
                    esc_pend  <= 1'b0;
                end else if (esc_active && in_data == esc_char) begin
                    esc_pend <= 1'b1;
                end else if (in_data == xoff_char) begin
                    paused <= 1'b1;
                end else if (in_data == xon_char) begin
                    paused <= 1'b0;
                end else begin
                    out_valid <= 1'b1;
                    out_data  <= in_data;
                end
            end
        end
    end
endmodule

// File: rtl/fc_irq_status.sv
// Interrupt status: sticky pause-received and modem-change flags,
// masked by mode and enables; set has priority over clear.
// Assumes cts_n is already synchronized to clk.
module fc_irq_status
    import uart_fc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  fc_mode_e         mode,
    input  logic             en_xoff,
    input  logic             en_rts,
    input  logic             en_cts,
    input  logic             xoff_hit,
    input  logic             cts_n,
    input  logic             rts_n,
    input  logic [IRQ_N-1:0] clr,
    output logic [IRQ_N-1:0] flags,
    output logic             irq
);
    logic             cts_prev;
    logic             rts_prev;
    logic [IRQ_N-1:0] set_vec;

    // Build this cycle's set requests.
    always_comb begin
        set_vec           = '0;
        set_vec[IRQ_XOFF] = xoff_hit && en_xoff && (mode == FC_SW);
        set_vec[IRQ_RTS]  = (mode == FC_HW) && en_rts && (rts_n != rts_prev);
        set_vec[IRQ_CTS]  = (mode == FC_HW) && en_cts && (cts_n != cts_prev);
        irq               = |flags;
    end

    // Track line history and update sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_prev <= 1'b1;
            rts_prev <= 1'b1;
            flags    <= '0;
        end else begin
            cts_prev <= cts_n;
            rts_prev <= rts_n;
            flags    <= (flags & ~clr) | set_vec;
        end
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
// Top: UART flow controller. Joins the mode decoder, transmit gate,
// receive filter and interrupt status, and drives rts_n from the receive
// FIFO level. Configuration inputs are assumed quasi-static.
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int LEVEL_W      = 5,
    parameter int RX_HIGH_MARK = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         cfg_feature,
    input  logic [7:0]         cfg_ier,
    input  logic [DATA_W-1:0]  cfg_xon1,
    input  logic [DATA_W-1:0]  cfg_xoff1,
    input  logic [DATA_W-1:0]  cfg_xon2,
    input  logic [DATA_W-1:0]  cfg_xoff2,
    input  logic [DATA_W-1:0]  cfg_esc_char,
    input  logic               cfg_esc_en,
    input  logic               tx_in_valid,
    input  logic [DATA_W-1:0]  tx_in_data,
    output logic               tx_in_ready,
    output logic               tx_out_valid,
    output logic [DATA_W-1:0]  tx_out_data,
    input  logic               tx_out_ready,
    input  logic               rx_in_valid,
    input  logic [DATA_W-1:0]  rx_in_data,
    output logic               rx_out_valid,
    output logic [DATA_W-1:0]  rx_out_data,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               cts_n,
    output logic               rts_n,
    input  logic [2:0]         irq_clr,
    output logic [2:0]         irq_flags,
    output logic               irq
);
    localparam logic [LEVEL_W-1:0] HIGH_MARK = LEVEL_W'(RX_HIGH_MARK);

    fc_mode_e          mode;
    logic              auto_cts;
    logic              auto_rts;
    logic [DATA_W-1:0] xon_c;
    logic [DATA_W-1:0] xoff_c;
    logic              sw_mode;
    logic              esc_active;
    logic              tx_paused;
    logic              xoff_hit;
    logic              cfg_unused;

    // Derive software-mode and escaping qualifiers.
    always_comb begin
        sw_mode    = (mode == FC_SW);
        esc_active = sw_mode && cfg_esc_en;
        cfg_unused = ^{cfg_feature[5], cfg_ier[4:0]};
    end

    // Request-to-send follows the receive FIFO level when automatic.
    always_ff @(posedge clk) begin
        if (!rst_n) rts_n <= 1'b1;
        else        rts_n <= auto_rts ? (rx_level >= HIGH_MARK) : 1'b0;
    end

    fc_mode_decode #(.DATA_W(DATA_W)) u_dec (
        .feature  (cfg_feature),
        .xon1     (cfg_xon1),
        .xoff1    (cfg_xoff1),
        .xon2     (cfg_xon2),
        .xoff2    (cfg_xoff2),
        .mode     (mode),
        .auto_cts (auto_cts),
        .auto_rts (auto_rts),
        .xon_sel  (xon_c),
        .xoff_sel (xoff_c)
    );

    fc_tx_gate #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (tx_in_valid),
        .in_data    (tx_in_data),
        .in_ready   (tx_in_ready),
        .out_valid  (tx_out_valid),
        .out_data   (tx_out_data),
        .out_ready  (tx_out_ready),
        .esc_active (esc_active),
        .esc_char   (cfg_esc_char),
        .xon_char   (xon_c),
        .xoff_char  (xoff_c),
        .auto_cts   (auto_cts),
        .cts_n      (cts_n),
        .paused     (tx_paused)
    );

    fc_rx_filter #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_in_valid),
        .in_data    (rx_in_data),
        .sw_active  (sw_mode),
        .esc_active (esc_active),
        .esc_char   (cfg_esc_char),
        .xon_char   (xon_c),
        .xoff_char  (xoff_c),
        .out_valid  (rx_out_valid),
        .out_data   (rx_out_data),
        .paused     (tx_paused),
        .xoff_hit   (xoff_hit)
    );

    fc_irq_status u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .en_xoff  (cfg_ier[IER_XOFF_BIT]),
        .en_rts   (cfg_ier[IER_RTS_BIT]),
        .en_cts   (cfg_ier[IER_CTS_BIT]),
        .xoff_hit (xoff_hit),
        .cts_n    (cts_n),
        .rts_n    (rts_n),
        .clr      (irq_clr),
        .flags    (irq_flags),
        .irq      (irq)
    );
endmodule

// File: rtl/uart_flow_ctrl_chk.sv
// Checker: temporal properties of the flow controller, bound to the top.
module uart_flow_ctrl_chk #(
    parameter int DATA_W       = 8,
    parameter int LEVEL_W      = 5,
    parameter int RX_HIGH_MARK = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sw_mode,
    input logic               auto_cts,
    input logic               auto_rts,
    input logic               cts_n,
    input logic               rts_n,
    input logic [LEVEL_W-1:0] rx_level,
    input logic               tx_in_valid,
    input logic               tx_in_ready,
    input logic               tx_out_valid,
    input logic               tx_out_ready,
    input logic               tx_paused,
    input logic               rx_in_valid,
    input logic [DATA_W-1:0]  rx_in_data,
    input logic               rx_out_valid,
    input logic [DATA_W-1:0]  rx_out_data,
    input logic [2:0]         irq_flags,
    input logic [2:0]         irq_clr
);
    // R3: off software mode, every received byte is forwarded next cycle
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_mode && rx_in_valid) |=> (rx_out_valid && rx_out_data == $past(rx_in_data)));

    // R4: no character offered while CTS is deasserted under automatic CTS
    p_cts_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts && cts_n) |-> !tx_out_valid);

    // R5: rts_n tracks the previous cycle's level against the mark
    p_rts_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auto_rts |=> (rts_n == ($past(rx_level) >= LEVEL_W'(RX_HIGH_MARK))));

    // R6: a FIFO pop only happens together with an accepted character
    p_pop_with_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_ready) |-> (tx_out_valid && tx_out_ready));

    // R9: the pause state from the receiver blocks the transmitter
    p_pause_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_paused |-> !tx_out_valid);

    // R10: the pause-received flag holds until cleared
    p_xoff_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[0] && !irq_clr[0]) |=> irq_flags[0]);
endmodule

bind uart_flow_ctrl uart_flow_ctrl_chk #(
    .DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .RX_HIGH_MARK(RX_HIGH_MARK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_mode      (sw_mode),
    .auto_cts     (auto_cts),
    .auto_rts     (auto_rts),
    .cts_n        (cts_n),
    .rts_n        (rts_n),
    .rx_level     (rx_level),
    .tx_in_valid  (tx_in_valid),
    .tx_in_ready  (tx_in_ready),
    .tx_out_valid (tx_out_valid),
    .tx_out_ready (tx_out_ready),
    .tx_paused    (tx_paused),
    .rx_in_valid  (rx_in_valid),
    .rx_in_data   (rx_in_data),
    .rx_out_valid (rx_out_valid),
    .rx_out_data  (rx_out_data),
    .irq_flags    (irq_flags),
    .irq_clr      (irq_clr)
);

// File: tb/sim_uart_flow_ctrl.sv
`timescale 1ns/1ps
module sim_uart_flow_ctrl;
    localparam int MARK = 12;
    localparam logic [7:0] ESC = 8'hDB;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_feature, cfg_ier, cfg_xon1, cfg_xoff1, cfg_xon2, cfg_xoff2, cfg_esc_char;
    logic       cfg_esc_en;
    logic       tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
    logic [7:0] tx_in_data, tx_out_data;
    logic       rx_in_valid, rx_out_valid;
    logic [7:0] rx_in_data, rx_out_data;
    logic [4:0] rx_level;
    logic       cts_n, rts_n, irq;
    logic [2:0] irq_clr, irq_flags;

    int checks = 0;
    int errors = 0;
    logic [7:0] cur_xon, cur_xoff;

    always #2.5 clk = ~clk;

    uart_flow_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_feature(cfg_feature), .cfg_ier(cfg_ier),
        .cfg_xon1(cfg_xon1), .cfg_xoff1(cfg_xoff1), .cfg_xon2(cfg_xon2), .cfg_xoff2(cfg_xoff2),
        .cfg_esc_char(cfg_esc_char), .cfg_esc_en(cfg_esc_en),
        .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .rx_level(rx_level), .cts_n(cts_n), .rts_n(rts_n),
        .irq_clr(irq_clr), .irq_flags(irq_flags), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic need_esc(input logic [7:0] b, input logic en);
        return en && (b == cur_xon || b == cur_xoff || b == ESC);
    endfunction

    // Offer one byte and follow it through one or two characters.
    task automatic push_tx(input logic [7:0] b, input logic en, input string req);
        tx_in_valid  = 1'b1;
        tx_in_data   = b;
        tx_out_ready = 1'b1;
        #1;
        if (need_esc(b, en)) begin
            chk(req, tx_out_data, ESC);
            chk(req, tx_in_ready, 1'b0);
            tick();
            chk(req, tx_out_data, b ^ 8'h20);
            chk(req, tx_in_ready, 1'b1);
        end else begin
            chk(req, tx_out_data, b);
            chk(req, tx_in_ready, 1'b1);
        end
        tick();
        tx_in_valid  = 1'b0;
        tx_out_ready = 1'b0;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        rx_in_valid = 1'b1;
        rx_in_data  = b;
        tick();
        rx_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; cfg_feature = 8'h00; cfg_ier = 8'h00;
        cfg_xon1 = 8'h11; cfg_xoff1 = 8'h13; cfg_xon2 = 8'h51; cfg_xoff2 = 8'h53;
        cfg_esc_char = ESC; cfg_esc_en = 1'b0;
        tx_in_valid = 0; tx_in_data = 0; tx_out_ready = 0;
        rx_in_valid = 0; rx_in_data = 0; rx_level = 0; cts_n = 1'b1; irq_clr = 0;
        cur_xon = 8'h11; cur_xoff = 8'h13;
        repeat (3) tick();
        // R1: state while reset is held
        chk("R1 rts_n", rts_n, 1'b1);
        chk("R1 rx_out_valid", rx_out_valid, 1'b0);
        chk("R1 irq_flags", irq_flags, 3'b000);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R5 rts_n without auto", rts_n, 1'b0);
        cfg_ier = 8'hE0;

        // R3: off mode, directed control bytes then random bytes
        push_tx(8'h13, 1'b0, "R3 tx");
        rx_byte(8'h13);
        chk("R3 rx valid", rx_out_valid, 1'b1);
        chk("R3 rx data", rx_out_data, 8'h13);
        rx_byte(ESC);
        chk("R3 rx esc data", rx_out_data, ESC);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            push_tx(b, 1'b0, "R3 tx random");
            rx_byte(b);
            chk("R3 rx random valid", rx_out_valid, 1'b1);
            chk("R3 rx random data", rx_out_data, b);
        end
        cts_n = 1'b0;
        tick();
        tick();
        chk("R11 masked in off mode", irq_flags, 3'b000);

        // R6: software mode with pair 1 and escaping
        cfg_feature = 8'h1A; cfg_esc_en = 1'b1;
        push_tx(8'h11, 1'b1, "R6 xon");
        push_tx(8'h13, 1'b1, "R6 xoff");
        push_tx(ESC, 1'b1, "R6 esc");
        push_tx(8'h51, 1'b1, "R2 pair2 char unescaped");
        for (int i = 0; i < 24; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (i % 4 == 0) b = 8'h13;
            if (i % 4 == 1) b = ESC;
            push_tx(b, 1'b1, "R6 random");
        end

        // R8: escaped control byte is data, not a pause
        rx_byte(ESC);
        chk("R8 esc dropped", rx_out_valid, 1'b0);
        rx_byte(8'h33);
        chk("R8 unescaped valid", rx_out_valid, 1'b1);
        chk("R8 unescaped data", rx_out_data, 8'h13);
        tx_in_valid = 1'b1; tx_in_data = 8'h41; #1;
        chk("R8 no pause", tx_out_valid, 1'b1);
        chk("R8 no flag", irq_flags, 3'b000);

        // R9 / R10: pause and resume
        rx_byte(8'h13);
        #1;
        chk("R9 xoff not forwarded", rx_out_valid, 1'b0);
        chk("R9 paused", tx_out_valid, 1'b0);
        chk("R10 flag set", irq_flags, 3'b001);
        chk("R12 irq", irq, 1'b1);
        tick();
        chk("R9 still paused", tx_out_valid, 1'b0);
        chk("R10 sticky", irq_flags[0], 1'b1);
        rx_byte(8'h11);
        #1;
        chk("R9 xon not forwarded", rx_out_valid, 1'b0);
        chk("R9 resumed", tx_out_valid, 1'b1);
        tx_in_valid = 1'b0;

        // R2: hardware bits ignored when software mode selected
        cfg_feature = 8'hDA; cts_n = 1'b1;
        push_tx(8'h41, 1'b1, "R2 cts ignored in sw mode");

        // R10 / R12: clear and set-over-clear
        irq_clr = 3'b001; tick(); irq_clr = 3'b000;
        chk("R10 cleared", irq_flags, 3'b000);
        chk("R12 irq low", irq, 1'b0);
        irq_clr = 3'b001;
        rx_byte(8'h13);
        irq_clr = 3'b000;
        chk("R12 set wins", irq_flags[0], 1'b1);
        rx_byte(8'h11);
        irq_clr = 3'b111; tick(); irq_clr = 3'b000;
        cfg_ier = 8'h00;
        rx_byte(8'h13);
        tx_in_valid = 1'b1; tx_in_data = 8'h41; #1;
        chk("R10 masked no flag", irq_flags, 3'b000);
        chk("R9 paused with irq masked", tx_out_valid, 1'b0);
        tx_in_valid = 1'b0;
        rx_byte(8'h11);
        cfg_ier = 8'hE0;

        // R7: escaping disabled
        cfg_esc_en = 1'b0;
        push_tx(8'h13, 1'b0, "R7 tx unescaped");
        rx_byte(ESC);
        chk("R7 esc forwarded valid", rx_out_valid, 1'b1);
        chk("R7 esc forwarded data", rx_out_data, ESC);

        // R2: pair 2 selection
        cfg_feature = 8'h15; cfg_esc_en = 1'b1; cur_xon = 8'h51; cur_xoff = 8'h53;
        push_tx(8'h11, 1'b1, "R2 pair1 char not escaped");
        push_tx(8'h53, 1'b1, "R2 pair2 xoff escaped");
        rx_byte(8'h13);
        chk("R2 pair1 xoff is data", rx_out_valid, 1'b1);
        rx_byte(8'h53);
        tx_in_valid = 1'b1; tx_in_data = 8'h41; #1;
        chk("R2 pair2 xoff pauses", tx_out_valid, 1'b0);
        tx_in_valid = 1'b0;
        rx_byte(8'h51);
        cfg_feature = 8'h0A;
        rx_byte(8'h13);
        chk("R2 enable bit clear passes", rx_out_data, 8'h13);

        // R4: automatic CTS
        cfg_feature = 8'h90; cts_n = 1'b1;
        tx_in_valid = 1'b1; tx_in_data = 8'h41; tx_out_ready = 1'b1; #1;
        chk("R4 blocked valid", tx_out_valid, 1'b0);
        chk("R4 blocked ready", tx_in_ready, 1'b0);
        cts_n = 1'b0; #1;
        chk("R4 open valid", tx_out_valid, 1'b1);
        chk("R4 open data", tx_out_data, 8'h41);
        tx_in_valid = 1'b0; tx_out_ready = 1'b0;
        rx_level = 5'd20; tick(); tick();
        chk("R5 no auto rts", rts_n, 1'b0);
        rx_level = 5'd0;

        // R5 / R11: automatic RTS and modem-change flags
        cfg_feature = 8'hD0;
        tick();
        irq_clr = 3'b111; tick(); irq_clr = 3'b000;
        rx_level = 5'(MARK - 1); tick();
        chk("R5 below mark", rts_n, 1'b0);
        rx_level = 5'(MARK); tick();
        chk("R5 at mark", rts_n, 1'b1);
        tick();
        chk("R11 rts flag", irq_flags, 3'b010);
        rx_level = 5'd0; tick();
        chk("R5 drained", rts_n, 1'b0);
        tick();
        irq_clr = 3'b111; tick(); irq_clr = 3'b000;
        cts_n = 1'b1; tick();
        chk("R11 cts flag", irq_flags, 3'b100);
        chk("R12 irq from cts", irq, 1'b1);
        cfg_ier = 8'h40;
        irq_clr = 3'b111; tick(); irq_clr = 3'b000;
        cts_n = 1'b0; tick();
        chk("R11 cts masked by enable", irq_flags, 3'b000);
        for (int i = 0; i < 12; i++) begin
            logic [4:0] lvl;
            lvl = 5'($urandom);
            rx_level = lvl;
            tick();
            chk("R5 random level", rts_n, (lvl >= 5'(MARK)));
        end
        finish_run();
    end
endmodule